// File: doc/BRIEF.md
# Page Write Latch and Timer

This block sits behind a serial-bus slave front end and turns one write transaction into a single self-timed commit of up to sixteen bytes. The front end reports bus events to it as one-cycle pulses: a START, a completed address byte, each completed data byte, each clock rising edge inside a following byte, and a STOP. The block keeps a sixteen-entry page buffer with a valid flag per entry. The upper address bits select the page. A four-bit pointer selects the entry and wraps inside the page.

A STOP that comes straight after an acknowledged data byte starts the commit. The block then raises `busy_o` for a fixed number of clock cycles. During that time it copies every valid buffer entry into its memory array and ignores all bus events. The front end uses `busy_o` to withhold every ACK, including the ACK of a select byte. A master can therefore poll until the array accepts it again. A write-protect level is watched from START until the address byte completes. If it is seen high in that window, the data bytes are refused and the array is left as it is. A synchronous read port exposes the array.

Top module: `page_commit_ctl`

## Requirements
- R1: After reset `busy_o` and `data_ack_o` are 0 and every array byte reads FFh.
- R2: A data byte accepted after address A is committed to array location A; bytes of the array that were not written keep their value.
- R3: After each accepted data byte only the low 4 address bits advance. They wrap from 15 to 0 inside the same page, and a later byte overwrites an earlier one that landed on the same entry.
- R4: A commit starts only when `stop_i` arrives with no `bit_i` pulse since the last accepted data byte. A STOP after a `bit_i` pulse, or right after the address byte, leaves `busy_o` low and the array unchanged.
- R5: If `wc_i` is 1 in any cycle from `start_i` up to and including `addr_vld_i`, then `data_ack_o` stays 0, no byte is buffered and nothing is committed. `wc_i` after the address byte has no effect.
- R6: `busy_o` rises in the cycle after the triggering `stop_i` and stays 1 for exactly `TW_CYCLES` cycles.
- R7: While `busy_o` is 1, every pulse on `start_i`, `addr_vld_i`, `data_vld_i`, `bit_i` and `stop_i` is ignored, and `data_ack_o` is 0.
- R8: Only buffer entries written in the current transaction reach the array. Entries left over from earlier transactions, or from discarded ones, are never programmed.
- R9: The read port returns the byte at `rd_addr_i` one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wc_i | input | 1 | Write-protect level |
| start_i | input | 1 | START or repeated START seen |
| addr_vld_i | input | 1 | Address byte complete |
| addr_i | input | ADDR_W | Byte address |
| data_vld_i | input | 1 | Write data byte complete |
| data_i | input | 8 | Write data byte |
| bit_i | input | 1 | Clock rising edge of a bit after the data ACK slot |
| stop_i | input | 1 | STOP seen |
| data_ack_o | output | 1 | Front end may ACK data bytes |
| busy_o | output | 1 | Commit in progress; withhold all ACKs |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data, one cycle latency |

## Verification
The bench drives each event pulse from one falling edge to the next, so the block samples it on exactly one rising edge. It reads `busy_o` and `data_ack_o` at the falling edge right after that rising edge. `busy_o` is expected high at the first falling edge after a committing STOP. The bench then counts the falling edges that see it high and expects exactly `TW_CYCLES`. In the test that sends events while busy, the falling edges those events use are subtracted from that count. Read data is checked one falling edge after the read address is driven, which matches the single register on the read path.

// File: rtl/page_commit_ctl.sv
module page_commit_ctl #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int TW_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wc_i,
  input  logic              start_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [7:0]        data_i,
  input  logic              bit_i,
  input  logic              stop_i,
  output logic              data_ack_o,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(TW_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TW_CYCLES - 1);
  localparam logic [CNT_W:0]   CNT_PAGE = (CNT_W+1)'(PAGE_N);

  logic [7:0]        mem   [DEPTH];
  logic [7:0]        latch [PAGE_N];
  logic [PAGE_N-1:0] vld;
  logic [HI_W-1:0]   page;
  logic [PAGE_W-1:0] ptr;
  logic              in_sel, addr_seen, prot, armed, busy;
  logic [CNT_W-1:0]  cnt;
  logic [PAGE_W-1:0] widx;
  logic              wr_en;
  logic              take_data;

  assign busy_o     = busy;
  assign data_ack_o = addr_seen & ~prot & ~busy;
  assign take_data  = data_vld_i & addr_seen & ~prot;
  assign widx       = cnt[PAGE_W-1:0];
  assign wr_en      = busy && ({1'b0, cnt} < CNT_PAGE) && vld[widx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sel    <= 1'b0;
      addr_seen <= 1'b0;
      prot      <= 1'b0;
      armed     <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      vld       <= '0;
      page      <= '0;
      ptr       <= '0;
    end else if (busy) begin
      if (cnt == CNT_LAST) begin
        busy <= 1'b0;
        vld  <= '0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (start_i) begin
      in_sel    <= 1'b1;
      addr_seen <= 1'b0;
      prot      <= wc_i;
      armed     <= 1'b0;
      vld       <= '0;
    end else if (stop_i) begin
      in_sel    <= 1'b0;
      addr_seen <= 1'b0;
      armed     <= 1'b0;
      if (armed) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else begin
        vld <= '0;
      end
    end else begin
      if (in_sel && wc_i) prot <= 1'b1;
      if (in_sel && addr_vld_i) begin
        page      <= addr_i[ADDR_W-1:PAGE_W];
        ptr       <= addr_i[PAGE_W-1:0];
        addr_seen <= 1'b1;
        in_sel    <= 1'b0;
      end
      if (take_data) begin
        vld[ptr] <= 1'b1;
        ptr      <= ptr + 1'b1;
        armed    <= 1'b1;
      end else if (bit_i) begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!busy && !start_i && !stop_i && take_data) latch[ptr] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      rd_data_o <= '0;
    end else begin
      if (wr_en) mem[{page, widx}] <= latch[widx];
      rd_data_o <= mem[rd_addr_i];
    end
  end
endmodule

// File: rtl/page_commit_ctl_chk.sv
module page_commit_ctl_chk #(
  parameter int PAGE_N = 16,
  parameter int CNT_W  = 6,
  parameter int TW_CYCLES = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              stop_i,
  input logic              wc_i,
  input logic              addr_vld_i,
  input logic              data_vld_i,
  input logic              bit_i,
  input logic              busy_o,
  input logic              data_ack_o,
  input logic              armed,
  input logic              in_sel,
  input logic [CNT_W-1:0]  cnt,
  input logic [PAGE_N-1:0] vld
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy_o && !data_ack_o));

  p_commit_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i && armed));

  p_bit_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && bit_i && !data_vld_i && !start_i && !stop_i) |=> !armed);

  p_prot_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && in_sel && addr_vld_i && wc_i && !start_i && !stop_i) |=> !data_ack_o);

  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt != CNT_W'(TW_CYCLES - 1)) |=> busy_o);

  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt == CNT_W'(TW_CYCLES - 1)) |=> !busy_o);

  p_busy_noack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !data_ack_o);

  p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (vld == '0));
endmodule

bind page_commit_ctl page_commit_ctl_chk #(
  .PAGE_N(PAGE_N), .CNT_W(CNT_W), .TW_CYCLES(TW_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .wc_i(wc_i),
  .addr_vld_i(addr_vld_i), .data_vld_i(data_vld_i), .bit_i(bit_i),
  .busy_o(busy_o), .data_ack_o(data_ack_o), .armed(armed), .in_sel(in_sel),
  .cnt(cnt), .vld(vld)
);

// File: tb/sim_page_commit_ctl.sv
`timescale 1ns/1ps
module sim_page_commit_ctl;
  localparam int AW = 8;
  localparam int TW = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wc_i = 0, start_i = 0, addr_vld_i = 0, data_vld_i = 0, bit_i = 0, stop_i = 0;
  logic [AW-1:0] addr_i = '0, rd_addr_i = '0;
  logic [7:0] data_i = '0, rd_data_o;
  logic data_ack_o, busy_o;
  int checks = 0, errs = 0;

  always #2.5 clk = ~clk;

  page_commit_ctl #(.ADDR_W(AW), .PAGE_W(4), .TW_CYCLES(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .wc_i(wc_i), .start_i(start_i),
    .addr_vld_i(addr_vld_i), .addr_i(addr_i), .data_vld_i(data_vld_i),
    .data_i(data_i), .bit_i(bit_i), .stop_i(stop_i), .data_ack_o(data_ack_o),
    .busy_o(busy_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic p_start();  @(negedge clk) start_i = 1; @(negedge clk) start_i = 0; endtask
  task automatic p_stop();   @(negedge clk) stop_i = 1;  @(negedge clk) stop_i = 0;  endtask
  task automatic p_bit();    @(negedge clk) bit_i = 1;   @(negedge clk) bit_i = 0;   endtask
  task automatic p_addr(input logic [AW-1:0] a);
    @(negedge clk) begin addr_i = a; addr_vld_i = 1; end
    @(negedge clk) addr_vld_i = 0;
  endtask
  task automatic p_data(input logic [7:0] d);
    @(negedge clk) begin data_i = d; data_vld_i = 1; end
    @(negedge clk) data_vld_i = 0;
  endtask
  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    @(negedge clk) rd_addr_i = a;
    @(negedge clk) chk(tag, rd_data_o, exp);
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 10*TW) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 data_ack", data_ack_o, 0);
    rd_chk("R1 mem00", 8'h00, 8'hFF);
    rd_chk("R1 mem55", 8'h55, 8'hFF);
    rd_chk("R1 memFF", 8'hFF, 8'hFF);
  endtask

  task automatic t_byte_write();
    int n;
    p_start(); p_addr(8'h05);
    chk("R5 ack open", data_ack_o, 1);
    p_data(8'hA5); p_stop();
    chk("R6 busy rise", busy_o, 1);
    chk("R7 ack busy", data_ack_o, 0);
    wait_idle(n);
    chk("R6 busy length", n, TW);
    rd_chk("R2 mem05", 8'h05, 8'hA5);
    rd_chk("R2 mem04", 8'h04, 8'hFF);
    rd_chk("R2 mem06", 8'h06, 8'hFF);
    @(negedge clk) rd_addr_i = 8'h05;
    @(negedge clk) rd_addr_i = 8'h04;
    chk("R9 latency old", rd_data_o, 8'hA5);
    @(negedge clk) chk("R9 latency new", rd_data_o, 8'hFF);
  endtask

  task automatic t_page_wrap();
    int n;
    p_start(); p_addr(8'h1E);
    for (int k = 0; k < 18; k++) p_data(8'(8'h30 + k));
    p_stop(); wait_idle(n);
    chk("R6 wrap busy", n, TW);
    for (int k = 0; k < 14; k++) rd_chk("R3 wrap low", 8'(8'h10 + k), 8'(8'h30 + k + 2));
    rd_chk("R3 over1E", 8'h1E, 8'h40);
    rd_chk("R3 over1F", 8'h1F, 8'h41);
    rd_chk("R3 next page", 8'h20, 8'hFF);
    rd_chk("R3 prev page", 8'h0F, 8'hFF);
  endtask

  task automatic t_discard();
    int n;
    p_start(); p_addr(8'h40); p_data(8'h11); p_data(8'h22); p_bit(); p_stop();
    chk("R4 late stop", busy_o, 0);
    p_start(); p_addr(8'h60); p_stop();
    chk("R4 stop after addr", busy_o, 0);
    rd_chk("R4 mem40", 8'h40, 8'hFF);
    p_start(); p_addr(8'h44); p_data(8'h77); p_stop(); wait_idle(n);
    rd_chk("R8 mem40 stale", 8'h40, 8'hFF);
    rd_chk("R8 mem41 stale", 8'h41, 8'hFF);
    rd_chk("R2 mem44", 8'h44, 8'h77);
  endtask

  task automatic t_wc();
    int n;
    p_start();
    @(negedge clk) wc_i = 1;
    @(negedge clk) wc_i = 0;
    p_addr(8'h50);
    chk("R5 ack refused", data_ack_o, 0);
    p_data(8'h99); p_stop();
    chk("R5 no commit", busy_o, 0);
    rd_chk("R5 mem50", 8'h50, 8'hFF);
    p_start(); p_addr(8'h51);
    @(negedge clk) wc_i = 1;
    @(negedge clk) chk("R5 late wc", data_ack_o, 1);
    p_data(8'h42); p_stop();
    chk("R5 late wc busy", busy_o, 1);
    wc_i = 0;
    wait_idle(n);
    rd_chk("R5 mem51", 8'h51, 8'h42);
  endtask

  task automatic t_busy_ignore();
    int n;
    p_start(); p_addr(8'h70); p_data(8'h12); p_stop();
    p_start(); p_addr(8'h71);
    chk("R7 ack during busy", data_ack_o, 0);
    p_data(8'h34); p_stop();
    wait_idle(n);
    chk("R7 busy length", n, TW - 8);
    rd_chk("R7 mem70", 8'h70, 8'h12);
    rd_chk("R7 mem71", 8'h71, 8'hFF);
  endtask

  task automatic t_partial();
    int n;
    p_start(); p_addr(8'h83); p_data(8'hAA); p_stop(); wait_idle(n);
    p_start(); p_addr(8'h85); p_data(8'hBB); p_stop(); wait_idle(n);
    rd_chk("R8 mem83", 8'h83, 8'hAA);
    rd_chk("R8 mem84", 8'h84, 8'hFF);
    rd_chk("R8 mem85", 8'h85, 8'hBB);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_byte_write();
        t_page_wrap();
        t_discard();
        t_wc();
        t_busy_ignore();
        t_partial();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule